// File: doc/BRIEF.md
# Neighbour link handshake buffer

This block carries words in one direction between two neighbouring processing elements. It holds exactly one word. The sending element offers a word with a flow request. The receiving element takes the word with a fetch request. Two flags tie the two sides together. A data-ready flag is set when a word is written and means the buffer is full. A data-used flag is raised for one cycle after the receiver takes the word. With these flags, neither side has to run in step with the other.

Both sides share one clock, and either side may stall for any number of cycles. A sender that meets a full buffer, or the data-used cycle, sees busy and must hold its request. A receiver that fetches from an empty buffer sees a wait indication and must hold its fetch. The buffer never overwrites a word that has not been read, and the word on the receive side stays unchanged for as long as data-ready is high. The asynchronous active-low reset is released synchronously inside the block.

Top module: `hs_link`

## Requirements
- R1: Two cycles after the reset input is released, and while reset is held, rcv_ready, snd_busy and rcv_wait are all 0. Reset clears both the data-ready flag and the data-used flag.
- R2: A write is accepted in a cycle where snd_valid is 1 and snd_busy is 0. On the next cycle rcv_ready is 1, rcv_data equals the written word, and snd_busy is 1.
- R3: While rcv_ready is 1 and no fetch completes, a new snd_valid is refused. snd_busy stays 1, and rcv_data keeps the earlier word unchanged.
- R4: A fetch (rcv_consume = 1) while rcv_ready is 0 has no effect. rcv_ready stays 0 and snd_busy stays 0 on the next cycle unless a write was accepted.
- R5: A fetch completes in a cycle where rcv_consume and rcv_ready are both 1. On the next cycle rcv_ready is 0 and snd_busy is 1 (this is the data-used cycle). The cycle after that, snd_busy is 0.
- R6: A write offered during the data-used cycle is not accepted. The earliest cycle in which a write is accepted is the one after data-used.
- R7: Under any pattern of stalls on either side, every written word is delivered exactly once and in write order. Nothing is left in the buffer after the last fetch.
- R8: rcv_wait is 1 exactly when rcv_consume is 1 and rcv_ready is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| snd_valid | input | 1 | Flow request from the sending element |
| snd_data | input | DATA_W | Word offered by the sender |
| snd_busy | output | 1 | Buffer full or in the data-used cycle; request not accepted |
| rcv_consume | input | 1 | Fetch request from the receiving element |
| rcv_ready | output | 1 | Data-ready: a word is waiting |
| rcv_data | output | DATA_W | Held word, stable while rcv_ready is 1 |
| rcv_wait | output | 1 | Fetch is stalled because the buffer is empty |

## Verification
The bench writes into a full buffer and then checks that the stored word is unchanged. A design that allowed overwriting would deliver the later word and lose the first one. It also offers a write exactly in the data-used cycle. A design that accepted this write early would raise rcv_ready one cycle too soon, or would merge a read and a write into one cycle. The bench also fetches from an empty buffer, which must leave the flags unchanged; a faulty design would make up a phantom word. Finally, 16 passes with different stall densities on the two sides compare each delivered word against a counting sequence. Any loss, duplicate or reordering shows up there.

// File: rtl/hs_link_pkg.sv
package hs_link_pkg;
  // Flags exchanged between the two sides of one link.
  typedef struct packed {
    logic ready;  // word waiting for the receiver
    logic used;   // receiver took the word last cycle
  } link_flags_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/hs_sent_flag.sv
module hs_sent_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,   // write accepted
  input  logic clr_i,   // fetch completed
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = q_o;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  // Set and clear never coincide: a write needs the flag low, a fetch needs it high.
  p_set_clr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_i && clr_i));
endmodule

// File: rtl/hs_used_flag.sv
module hs_used_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,  // fetch completed this cycle
  output logic q_o
);
  logic q_d;

  always_comb begin
    q_d = take_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= 1'b0;
    else        q_o <= q_d;
  end

  // Data-used lasts a single cycle per word.
  p_used_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q_o |=> !q_o);
endmodule

// File: rtl/hs_word_reg.sv
module hs_word_reg #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_d;

  always_comb begin
    q_d = load_i ? d_i : q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_d;
  end
endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              snd_valid,
  input  logic [DATA_W-1:0] snd_data,
  output logic              snd_busy,
  input  logic              rcv_consume,
  output logic              rcv_ready,
  output logic [DATA_W-1:0] rcv_data,
  output logic              rcv_wait
);
  import hs_link_pkg::*;

  logic        rst_n;
  logic        wr_accept;
  logic        rd_take;
  link_flags_t flags;

  hs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  // Sender may write only when the buffer is empty and not in the data-used cycle.
  assign snd_busy  = flags.ready | flags.used;
  assign wr_accept = snd_valid & ~snd_busy;
  assign rd_take   = rcv_consume & flags.ready;

  hs_sent_flag u_sent (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (wr_accept),
    .clr_i (rd_take),
    .q_o   (flags.ready)
  );

  hs_used_flag u_used (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (rd_take),
    .q_o    (flags.used)
  );

  hs_word_reg #(.DATA_W(DATA_W)) u_word (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (wr_accept),
    .d_i    (snd_data),
    .q_o    (rcv_data)
  );

  assign rcv_ready = flags.ready;
  assign rcv_wait  = rcv_consume & ~flags.ready;

  // R2: an accepted write shows up as data-ready with the written word.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (snd_valid && !snd_busy) |=> (rcv_ready && rcv_data == $past(snd_data)));

  // R3: a waiting word is neither replaced nor lost until fetched.
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_ready && !rcv_consume) |=> (rcv_ready && $stable(rcv_data)));

  // R4: fetching from an empty buffer with no write does not create data.
  p_empty_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!rcv_ready && !(snd_valid && !snd_busy)) |=> !rcv_ready);

  // R5: a completed fetch empties the buffer and blocks the sender for one cycle.
  p_take_then_used_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_consume && rcv_ready) |=> (!rcv_ready && snd_busy));

  // R6: data-ready never rises straight out of a fetch cycle.
  p_no_same_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rcv_consume && rcv_ready) |=> ##1 !$rose(rcv_ready));
endmodule

// File: tb/sim_hs_link.sv
module sim_hs_link;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NW = 40;

  logic          clk = 1'b0;
  logic          arst_n = 1'b0;
  logic          snd_valid = 1'b0;
  logic [DW-1:0] snd_data = '0;
  logic          rcv_consume = 1'b0;
  logic          snd_busy;
  logic          rcv_ready;
  logic [DW-1:0] rcv_data;
  logic          rcv_wait;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_link #(.DATA_W(DW)) u0 (
    .clk         (clk),
    .arst_n      (arst_n),
    .snd_valid   (snd_valid),
    .snd_data    (snd_data),
    .snd_busy    (snd_busy),
    .rcv_consume (rcv_consume),
    .rcv_ready   (rcv_ready),
    .rcv_data    (rcv_data),
    .rcv_wait    (rcv_wait)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  task automatic run_pass(input int smask, input int rmask, input int seed, input int base);
    fork
      begin : sender
        logic [15:0] lf;
        int sent;
        lf = 16'(seed);
        sent = 0;
        while (sent < NW) begin
          @(negedge clk);
          lf = lfsr_next(lf);
          if ((int'(lf) & smask) == 0) begin
            snd_valid = 1'b1;
            snd_data  = DW'(base + sent);
          end else begin
            snd_valid = 1'b0;
          end
          #1;
          if (snd_valid && !snd_busy) sent++;
        end
        @(negedge clk);
        snd_valid = 1'b0;
      end
      begin : receiver
        logic [15:0] lr;
        int got;
        bit prev_ready;
        bit prev_took;
        logic [DW-1:0] prev_data;
        lr = 16'(seed ^ 16'h5a5a);
        got = 0;
        prev_ready = 1'b0;
        prev_took = 1'b0;
        prev_data = '0;
        while (got < NW) begin
          @(negedge clk);
          lr = lfsr_next(lr);
          rcv_consume = ((int'(lr) & rmask) == 0);
          #1;
          if (rcv_ready && prev_ready && !prev_took)
            chk(rcv_data == prev_data, "R3", "held word", int'(rcv_data), int'(prev_data));
          prev_took = 1'b0;
          if (rcv_consume && rcv_ready) begin
            chk(rcv_data == DW'(base + got), "R7", "word order", int'(rcv_data), base + got);
            got++;
            prev_took = 1'b1;
          end
          prev_ready = rcv_ready;
          prev_data  = rcv_data;
        end
        @(negedge clk);
        rcv_consume = 1'b0;
      end
    join
    repeat (3) @(negedge clk);
    #1;
    chk(!rcv_ready, "R7", "no extra word after pass", int'(rcv_ready), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    #1;
    chk(!rcv_ready && !snd_busy && !rcv_wait, "R1", "outputs in reset",
        int'({rcv_ready, snd_busy, rcv_wait}), 0);
    arst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!rcv_ready, "R1", "ready after reset", int'(rcv_ready), 0);
    chk(!snd_busy, "R1", "busy after reset", int'(snd_busy), 0);

    // R4 / R8: fetch from empty buffer
    rcv_consume = 1'b1;
    #1;
    chk(rcv_wait, "R8", "wait on empty fetch", int'(rcv_wait), 1);
    @(negedge clk);
    #1;
    chk(!rcv_ready, "R4", "empty fetch made no data", int'(rcv_ready), 0);
    chk(!snd_busy, "R4", "empty fetch left busy low", int'(snd_busy), 0);
    rcv_consume = 1'b0;
    #1;
    chk(!rcv_wait, "R8", "no wait without fetch", int'(rcv_wait), 0);

    // R2: single write
    snd_valid = 1'b1;
    snd_data  = 16'h1234;
    #1;
    chk(!snd_busy, "R2", "free before write", int'(snd_busy), 0);
    @(negedge clk);
    snd_valid = 1'b0;
    #1;
    chk(rcv_ready, "R2", "ready after write", int'(rcv_ready), 1);
    chk(rcv_data == 16'h1234, "R2", "word after write", int'(rcv_data), 16'h1234);
    chk(snd_busy, "R2", "busy when full", int'(snd_busy), 1);

    // R3: overwrite attempt
    snd_valid = 1'b1;
    snd_data  = 16'h5555;
    @(negedge clk);
    snd_valid = 1'b0;
    #1;
    chk(rcv_data == 16'h1234, "R3", "word not overwritten", int'(rcv_data), 16'h1234);
    chk(rcv_ready, "R3", "still ready", int'(rcv_ready), 1);

    // R5 / R6: fetch, then write offered in the data-used cycle
    rcv_consume = 1'b1;
    #1;
    chk(!rcv_wait, "R8", "no wait when ready", int'(rcv_wait), 0);
    @(negedge clk);
    rcv_consume = 1'b0;
    #1;
    chk(!rcv_ready, "R5", "empty after fetch", int'(rcv_ready), 0);
    chk(snd_busy, "R5", "busy in used cycle", int'(snd_busy), 1);
    snd_valid = 1'b1;
    snd_data  = 16'h0abc;
    @(negedge clk);
    #1;
    chk(!rcv_ready, "R6", "write in used cycle refused", int'(rcv_ready), 0);
    chk(!snd_busy, "R5", "busy cleared after used", int'(snd_busy), 0);
    @(negedge clk);
    snd_valid = 1'b0;
    #1;
    chk(rcv_ready, "R6", "held write accepted next", int'(rcv_ready), 1);
    chk(rcv_data == 16'h0abc, "R6", "held write word", int'(rcv_data), 16'h0abc);
    rcv_consume = 1'b1;
    @(negedge clk);
    rcv_consume = 1'b0;
    repeat (2) @(negedge clk);

    // R7: stall sweep on both sides
    for (int s = 0; s < 4; s++) begin
      for (int r = 0; r < 4; r++) begin
        run_pass((1 << s) - 1, (1 << r) - 1, 16'h1ace + s * 37 + r * 101, (s * 4 + r) * 100);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule